// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block is the receive-side front end of an I2C target. It filters the oversampled SCL and SDA lines, detects START, repeated START and STOP conditions, shifts in the addressing byte or bytes that follow a START, and decides whether the device is being addressed. When it is, the block drives SDA low for the acknowledge clock, raises a one-cycle match pulse, and reports the transfer direction and whether the address was the general call.

Two own addresses are held on plain configuration pins: a 7-bit address that is used in 7-bit mode, and a 10-bit address that is used when 10-bit mode is selected. In 10-bit mode the block handles the two-byte write header sequence. It also handles the read header that is sent after a repeated START. General-call recognition works in either mode and can be switched off. All pins are plain control and status signals. There is no data stream here, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_tgt_addr_detect`

## Requirements
- R1: After reset, `sda_drive_low`, `match_pulse`, `dir_read` and `gen_call` are all 0.
- R2: In 7-bit mode (`ten_bit_en`=0), a first byte whose upper seven bits, received MSB first, equal `own_addr7` and whose LSB is 0 is acknowledged. The block raises `match_pulse` for one cycle and sets `dir_read` to 0.
- R3: The same first byte with LSB=1 (read) is acknowledged, and `dir_read` is set to 1.
- R4: A first byte that matches no enabled address is not acknowledged and raises no `match_pulse`.
- R5: A first byte of 0x00 is acknowledged with `gen_call`=1 and `dir_read`=0 when `gc_en`=1, and is ignored when `gc_en`=0.
- R6: First bytes 0x02 and 0x03 (reserved 7-bit address 0000001) are never acknowledged, even when `own_addr7` equals 1.
- R7: In 10-bit mode, a first byte 11110 followed by `own_addr10[9:8]` and a 0 is acknowledged without a match pulse. A following byte equal to `own_addr10[7:0]` is acknowledged with `match_pulse` and `dir_read`=0, and any other second byte is not acknowledged. In this mode the 7-bit own address is not recognized.
- R8: After a repeated START, the read header (11110, `own_addr10[9:8]`, 1) is acknowledged with `match_pulse` and `dir_read`=1 only if a full 10-bit match occurred earlier in the same transaction. After a STOP it is not acknowledged.
- R9: A START at any point restarts address reception. A STOP returns the block to idle, releases SDA and clears `gen_call`.
- R10: `sda_drive_low` rises while SCL is low after the eighth address bit and falls after SCL falls at the end of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_addr7 | input | 7 | Own 7-bit address |
| own_addr10 | input | 10 | Own 10-bit address |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| gc_en | input | 1 | Enables general-call recognition |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| match_pulse | output | 1 | One-cycle pulse when the device is fully addressed |
| dir_read | output | 1 | Direction of the matched transfer, 1 = read |
| gen_call | output | 1 | Matched address was the general call |

## Verification
The bench uses the default `SYNC_STAGES`=3. It runs the bus with a quarter bit period of ten clocks, which is well above the filter and edge-detect latency. This lets every acknowledge be sampled as a bus-level low in the middle of the ninth SCL-high phase. The default filter depth also lets the bench check the timing of the SDA release before the next bit is driven. Its scenarios cover both addressing modes and the general-call and reserved codes. They also include a START that cuts into a half-sent byte, and a 10-bit read header sent both with and without a prior full match.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TEN_HDR = 5'b11110;
  localparam logic [6:0] RSV_ADDR = 7'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ACK1,
    ST_ADDR2,
    ST_ACK2,
    ST_HOLD
  } addr_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_raw};
  end

  assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] own_addr7,
  input  logic [9:0] own_addr10,
  input  logic       ten_bit_en,
  input  logic       gc_en,
  output logic       sda_drive_low,
  output logic       match_pulse,
  output logic       dir_read,
  output logic       gen_call
);
  addr_st_e          state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ten_ok;

  logic is_gc, is_rsv, is_hdr, is_hdr_wr;
  logic dec_ack, dec_match, dec_dir, dec_gc, dec_ten_ok;

  always_comb begin
    is_gc     = (shreg == '0);
    is_rsv    = (shreg[7:1] == RSV_ADDR);
    is_hdr    = (shreg[7:3] == TEN_HDR) && (shreg[2:1] == own_addr10[9:8]);
    is_hdr_wr = ten_bit_en && is_hdr && !shreg[0];
    dec_ack    = 1'b0;
    dec_match  = 1'b0;
    dec_dir    = 1'b0;
    dec_gc     = 1'b0;
    dec_ten_ok = ten_ok;
    if (state == ST_ADDR1) begin
      if (is_gc) begin
        dec_ack   = gc_en;
        dec_match = gc_en;
        dec_gc    = gc_en;
      end else if (is_rsv) begin
        dec_ack = 1'b0;
      end else if (ten_bit_en) begin
        if (is_hdr && !shreg[0]) begin
          dec_ack    = 1'b1;
          dec_ten_ok = 1'b0;
        end else if (is_hdr && ten_ok) begin
          dec_ack   = 1'b1;
          dec_match = 1'b1;
          dec_dir   = 1'b1;
        end
      end else if (shreg[7:1] == own_addr7) begin
        dec_ack   = 1'b1;
        dec_match = 1'b1;
        dec_dir   = shreg[0];
      end
    end else if (state == ST_ADDR2) begin
      if (shreg == own_addr10[7:0]) begin
        dec_ack    = 1'b1;
        dec_match  = 1'b1;
        dec_ten_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      shreg         <= '0;
      bit_cnt       <= '0;
      ten_ok        <= 1'b0;
      sda_drive_low <= 1'b0;
      match_pulse   <= 1'b0;
      dir_read      <= 1'b0;
      gen_call      <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (stop_det) begin
        state         <= ST_IDLE;
        bit_cnt       <= '0;
        ten_ok        <= 1'b0;
        sda_drive_low <= 1'b0;
        dir_read      <= 1'b0;
        gen_call      <= 1'b0;
      end else if (start_det) begin
        state         <= ST_ADDR1;
        bit_cnt       <= '0;
        sda_drive_low <= 1'b0;
        dir_read      <= 1'b0;
        gen_call      <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR1, ST_ADDR2: begin
            if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
              bit_cnt <= '0;
              ten_ok  <= dec_ten_ok;
              if (dec_ack) begin
                sda_drive_low <= 1'b1;
                match_pulse   <= dec_match;
                if (dec_match) begin
                  dir_read <= dec_dir;
                  gen_call <= dec_gc;
                end
                state <= (state == ST_ADDR1) ? ST_ACK1 : ST_ACK2;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK1: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              state         <= is_hdr_wr ? ST_ADDR2 : ST_HOLD;
            end
          end
          ST_ACK2: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              state         <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a match is always signalled together with the acknowledge drive
  a_r2_match_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> sda_drive_low);

  // R5: general call is a write
  a_r5_gc_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> !dir_read);

  // R6: reserved address never acknowledged
  a_r6_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_low) && state == ST_ACK1) |-> (shreg[7:1] != RSV_ADDR));

  // R9: STOP releases the line and clears the general-call flag
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_drive_low && !gen_call && state == ST_IDLE));

  // R10: acknowledge drive begins while SCL is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_lvl);

  // R10: acknowledge drive ends only on an SCL fall or a bus condition
  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
endmodule

// File: rtl/i2c_tgt_addr_detect.sv
module i2c_tgt_addr_detect #(
  parameter int SYNC_STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr7,
  input  logic [9:0] own_addr10,
  input  logic       ten_bit_en,
  input  logic       gc_en,
  output logic       sda_drive_low,
  output logic       match_pulse,
  output logic       dir_read,
  output logic       gen_call
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, sync_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (raw_lines[g]),
      .line_sync(sync_lines[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (sync_lines[0]),
    .sda_s    (sync_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_addr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_lvl      (sync_lines[0]),
    .sda_lvl      (sync_lines[1]),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .own_addr7    (own_addr7),
    .own_addr10   (own_addr10),
    .ten_bit_en   (ten_bit_en),
    .gc_en        (gc_en),
    .sda_drive_low(sda_drive_low),
    .match_pulse  (match_pulse),
    .dir_read     (dir_read),
    .gen_call     (gen_call)
  );
endmodule

// File: tb/i2c_tgt_addr_detect_bench.sv
module i2c_tgt_addr_detect_bench;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [6:0] own_addr7 = 7'h2A;
  logic [9:0] own_addr10 = 10'h2B5;
  logic       ten_bit_en = 1'b0;
  logic       gc_en = 1'b1;
  logic       sda_drive_low, match_pulse, dir_read, gen_call;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {logic dir; logic gc;} exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_low;

  i2c_tgt_addr_detect u_i2c_tgt_addr_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .own_addr7(own_addr7), .own_addr10(own_addr10),
    .ten_bit_en(ten_bit_en), .gc_en(gc_en),
    .sda_drive_low(sda_drive_low), .match_pulse(match_pulse),
    .dir_read(dir_read), .gen_call(gen_call)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  // Sends eight bits MSB first, then clocks the acknowledge bit and checks it.
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    check(tag, ack, exp_ack);
    wq(); scl_m = 1'b0; wq();
    check("R10 release", sda_drive_low, 1'b0);
  endtask

  task automatic expect_match(input logic dir, input logic gc);
    exp_t e;
    e.dir = dir; e.gc = gc;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the expected match for every match pulse seen.
  always @(negedge clk) begin
    if (rst_n && match_pulse) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected match: actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R3 direction", dir_read, e.dir);
        check("R5 general-call flag", gen_call, e.gc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 drive", sda_drive_low, 1'b0);
    check("R1 match", match_pulse, 1'b0);
    check("R1 dir", dir_read, 1'b0);
    check("R1 gc", gen_call, 1'b0);
    rst_n = 1'b1;
    wq();

    // R2 write to own 7-bit address
    bus_start(); expect_match(1'b0, 1'b0); send_byte(8'h54, 1'b1, "R2 ack"); bus_stop();
    // R3 read
    bus_start(); expect_match(1'b1, 1'b0); send_byte(8'h55, 1'b1, "R3 ack"); bus_stop();
    // R4 other address
    bus_start(); send_byte(8'h56, 1'b0, "R4 nack"); bus_stop();
    // R5 general call enabled
    bus_start(); expect_match(1'b0, 1'b1); send_byte(8'h00, 1'b1, "R5 gc ack");
    check("R5 gc level", gen_call, 1'b1);
    bus_stop();
    check("R9 gc cleared by stop", gen_call, 1'b0);
    // R5 general call disabled
    gc_en = 1'b0;
    bus_start(); send_byte(8'h00, 1'b0, "R5 gc disabled"); bus_stop();
    gc_en = 1'b1;
    // R6 reserved address
    own_addr7 = 7'h01;
    bus_start(); send_byte(8'h02, 1'b0, "R6 0x02"); bus_stop();
    bus_start(); send_byte(8'h03, 1'b0, "R6 0x03"); bus_stop();
    own_addr7 = 7'h2A;
    // R9 START cutting a byte short
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start(); expect_match(1'b0, 1'b0); send_byte(8'h54, 1'b1, "R9 restart ack"); bus_stop();
    // R7/R8 ten-bit write then read after repeated START
    ten_bit_en = 1'b1;
    bus_start();
    send_byte(8'hF4, 1'b1, "R7 header ack");
    expect_match(1'b0, 1'b0); send_byte(8'hB5, 1'b1, "R7 low byte ack");
    bus_start(); expect_match(1'b1, 1'b0); send_byte(8'hF5, 1'b1, "R8 read header ack");
    bus_stop();
    // R7 low byte mismatch
    bus_start(); send_byte(8'hF4, 1'b1, "R7 header ack 2"); send_byte(8'hB4, 1'b0, "R7 low nack");
    bus_stop();
    // R8 read header without prior match
    bus_start(); send_byte(8'hF5, 1'b0, "R8 read nack"); bus_stop();
    // R7 7-bit own address ignored in ten-bit mode
    bus_start(); send_byte(8'h54, 1'b0, "R7 7-bit ignored"); bus_stop();
    ten_bit_en = 1'b0;

    wq();
    check("R4 expected matches consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule